// File: doc/BRIEF.md
# Secured JTAG Instruction Decoder

This block sits behind an IEEE 1149.1 TAP controller. It owns the 5-bit instruction register and turns the latched instruction into one-hot select lines. The lines pick which data register the TAP talks to: bypass, the 32-bit device identification register, the boundary-scan chain, the system-bus address+data register, or the system-bus data-only register. The TAP controller supplies single-cycle state indications (capture, shift and update for both the IR and DR paths, plus test-logic-reset). The block returns the serial outputs of the instruction register and of the data registers it implements itself. Chains kept elsewhere are forwarded through an external serial input.

A stored security fuse locks out the four debug memory-access instructions, which then fall back to bypass. A flash-controller reset input forces the lock on whatever the stored fuse holds. Only a chip-erase instruction clears the fuse, and only after the flash side confirms erase completion through a handshake input. Some instructions act directly on the system rather than on a register: target reset, chip erase, halt, access cancel and sync. Each produces a one-cycle strobe, and the target-reset instruction also holds a level reset while it stays active.

Top module: `jtag_secure_ir_decode`

## Requirements
- R1: After synchronous reset `rst`, and one cycle after `tap_reset` is high, the active instruction is IDCODE (5'h01) and `sel_idcode` is the only select asserted.
- R2: A cycle with `capture_ir` loads the instruction shift register with 5'b00001. Each following `shift_ir` cycle moves `tdi` in at the MSB end, and `ir_tdo` presents the LSB, so the first five shifted-out bits are 1,0,0,0,0.
- R3: `update_ir` makes the shifted code the active instruction (`active_ir`). The select lines are then as follows. 5'h01 gives idcode. 5'h02 (sample/preload), 5'h03 (extest) and 5'h04 (intest) give boundary scan. 5'h06 (clamp), 5'h0C (target reset), 5'h0F (chip erase), 5'h13 (cancel), 5'h17 (sync), 5'h1C (halt) and 5'h1F give bypass. 5'h10 (nexus), 5'h11 (word), 5'h14 (service) and 5'h15 (sized) give bus address+data. 5'h12 (block) gives bus data-only.
- R4: Every 5-bit code not listed in R3 behaves exactly like 5'h1F: bypass select only, no strobe, no boundary drive, no target reset.
- R5: While `sec_locked` is high, 5'h10, 5'h11, 5'h12 and 5'h15 select bypass and assert no bus select. 5'h14 and all other codes decode as in R3.
- R6: While `flash_rst` is high, `sec_locked` reads 1 and the R5 blocking applies, whatever the stored fuse value. The stored fuse loads from `fuse_prog_in` during `rst`.
- R7: Chip erase (5'h0F) gives a one-cycle `erase_stb`. After that, the first cycle with `erase_done` high clears the stored fuse, and access to the four restricted instructions returns. An `erase_done` with no erase pending has no effect.
- R8: Codes 5'h0C, 5'h0F, 5'h1C, 5'h13 and 5'h17 each pulse their own strobe (`reset_stb`, `erase_stb`, `halt_stb`, `cancel_stb`, `sync_stb`). The pulse lasts one cycle and appears in the cycle after the `update_ir` that loads the code, and again after each `update_dr` while the code is active.
- R9: `sys_reset` is high exactly while 5'h0C is the active instruction.
- R10: With bypass selected, `capture_dr` loads 0 into the one-bit bypass register. Each `shift_dr` moves `tdi` into it, so `dr_tdo` follows `tdi` one shift late.
- R11: With IDCODE selected, `capture_dr` loads `ID_VALUE` with bit 0 forced to 1, and `shift_dr` shifts it out LSB first on `dr_tdo`.
- R12: `bsr_drive` is 1 only for extest, intest and clamp. `bus_autoinc` is 1 only for the block access. `bus_mode` is 0 for word and block, 1 for sized, 2 for nexus and 3 for service.
- R13: Exactly one select line is high in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TAP-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_reset | input | 1 | TAP in Test-Logic-Reset |
| capture_ir | input | 1 | TAP in Capture-IR |
| shift_ir | input | 1 | TAP in Shift-IR |
| update_ir | input | 1 | TAP in Update-IR |
| capture_dr | input | 1 | TAP in Capture-DR |
| shift_dr | input | 1 | TAP in Shift-DR |
| update_dr | input | 1 | TAP in Update-DR |
| tdi | input | 1 | Serial test data in |
| ext_dr_tdo | input | 1 | Serial out of externally held chains |
| fuse_prog_in | input | 1 | Security fuse value loaded at reset |
| flash_rst | input | 1 | Flash controller held in reset |
| erase_done | input | 1 | Erase completion handshake |
| ir_tdo | output | 1 | Instruction shift register serial out |
| dr_tdo | output | 1 | Selected data register serial out |
| active_ir | output | 5 | Active instruction code |
| sel_bypass | output | 1 | Bypass register selected |
| sel_idcode | output | 1 | Device ID register selected |
| sel_bscan | output | 1 | Boundary-scan chain selected |
| sel_bus_ad | output | 1 | Bus address+data register selected |
| sel_bus_d | output | 1 | Bus data-only register selected |
| bsr_drive | output | 1 | Pins driven from boundary-scan register |
| bus_autoinc | output | 1 | Bus address advances after each transfer |
| bus_mode | output | 2 | Bus access flavour |
| sec_locked | output | 1 | Security lock in force |
| sys_reset | output | 1 | Level system reset |
| reset_stb | output | 1 | Target reset strobe |
| erase_stb | output | 1 | Chip erase request strobe |
| halt_stb | output | 1 | CPU halt strobe |
| cancel_stb | output | 1 | Access cancel strobe |
| sync_stb | output | 1 | Sync strobe |

## Verification
The hardest state to reach from the ports is the unlock path. The lock must hold through a stray `erase_done` and through the erase strobe itself, and it must lift only on the completion handshake that follows a chip erase. The bench starts from a reset with the fuse programmed, so this sequence is exercised directly. It first pulses `erase_done` with nothing pending and confirms the lock still holds. It then loads chip erase, checks the strobe while still locked, and only then completes the handshake. Next it raises `flash_rst` while a block access is active, to show the lock is forced on part way through an instruction. Finally, every one of the 32 codes is swept once unlocked and once locked.

// File: rtl/jid_pkg.sv
package jid_pkg;

    localparam int IR_W = 5;
    typedef logic [IR_W-1:0] opcode_t;

    localparam opcode_t OP_IDCODE   = 5'h01;
    localparam opcode_t OP_SAMPLE   = 5'h02;
    localparam opcode_t OP_EXTEST   = 5'h03;
    localparam opcode_t OP_INTEST   = 5'h04;
    localparam opcode_t OP_CLAMP    = 5'h06;
    localparam opcode_t OP_TGT_RST  = 5'h0C;
    localparam opcode_t OP_ERASE    = 5'h0F;
    localparam opcode_t OP_NEXUS    = 5'h10;
    localparam opcode_t OP_MEM_WORD = 5'h11;
    localparam opcode_t OP_MEM_BLK  = 5'h12;
    localparam opcode_t OP_CANCEL   = 5'h13;
    localparam opcode_t OP_SERVICE  = 5'h14;
    localparam opcode_t OP_MEM_SIZE = 5'h15;
    localparam opcode_t OP_SYNC     = 5'h17;
    localparam opcode_t OP_HALT     = 5'h1C;
    localparam opcode_t OP_BYPASS   = 5'h1F;

    localparam opcode_t IR_CAPTURE_PAT = 5'b00001;

    typedef enum logic [4:0] {
        SEL_BYPASS = 5'b00001,
        SEL_IDCODE = 5'b00010,
        SEL_BSCAN  = 5'b00100,
        SEL_BUS_AD = 5'b01000,
        SEL_BUS_D  = 5'b10000
    } dr_sel_e;

    typedef enum logic [1:0] {
        BUS_WORD    = 2'd0,
        BUS_SIZED   = 2'd1,
        BUS_NEXUS   = 2'd2,
        BUS_SERVICE = 2'd3
    } bus_mode_e;

    typedef struct packed {
        dr_sel_e   sel;
        logic      bsr_drive;
        logic      autoinc;
        bus_mode_e mode;
    } decode_t;

    typedef struct packed {
        logic sync;
        logic cancel;
        logic halt;
        logic erase;
        logic reset;
    } strobe_t;

    function automatic logic is_restricted(opcode_t op);
        return (op == OP_NEXUS) || (op == OP_MEM_WORD) ||
               (op == OP_MEM_BLK) || (op == OP_MEM_SIZE);
    endfunction

    function automatic decode_t decode_op(opcode_t op, logic locked);
        decode_t d;
        d = '{sel: SEL_BYPASS, bsr_drive: 1'b0, autoinc: 1'b0, mode: BUS_WORD};
        if (!(locked && is_restricted(op))) begin
            case (op)
                OP_IDCODE:   d.sel = SEL_IDCODE;
                OP_SAMPLE:   d.sel = SEL_BSCAN;
                OP_EXTEST:   begin d.sel = SEL_BSCAN; d.bsr_drive = 1'b1; end
                OP_INTEST:   begin d.sel = SEL_BSCAN; d.bsr_drive = 1'b1; end
                OP_CLAMP:    d.bsr_drive = 1'b1;
                OP_MEM_WORD: d.sel = SEL_BUS_AD;
                OP_MEM_SIZE: begin d.sel = SEL_BUS_AD; d.mode = BUS_SIZED; end
                OP_NEXUS:    begin d.sel = SEL_BUS_AD; d.mode = BUS_NEXUS; end
                OP_SERVICE:  begin d.sel = SEL_BUS_AD; d.mode = BUS_SERVICE; end
                OP_MEM_BLK:  begin d.sel = SEL_BUS_D; d.autoinc = 1'b1; end
                default:     d.sel = SEL_BYPASS;
            endcase
        end
        return d;
    endfunction

    function automatic strobe_t strobe_of(opcode_t op);
        strobe_t s;
        s        = '0;
        s.reset  = (op == OP_TGT_RST);
        s.erase  = (op == OP_ERASE);
        s.halt   = (op == OP_HALT);
        s.cancel = (op == OP_CANCEL);
        s.sync   = (op == OP_SYNC);
        return s;
    endfunction

endpackage

// File: rtl/jid_ir_reg.sv
module jid_ir_reg
    import jid_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tap_reset,
    input  logic    capture_ir,
    input  logic    shift_ir,
    input  logic    update_ir,
    input  logic    tdi,
    output opcode_t ir_sr,
    output opcode_t ir_q,
    output logic    ir_tdo
);

    always_ff @(posedge clk) begin
        if (rst || tap_reset) begin
            ir_sr <= IR_CAPTURE_PAT;
        end else if (capture_ir) begin
            ir_sr <= IR_CAPTURE_PAT;
        end else if (shift_ir) begin
            ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || tap_reset) begin
            ir_q <= OP_IDCODE;
        end else if (update_ir) begin
            ir_q <= ir_sr;
        end
    end

    assign ir_tdo = ir_sr[0];

    // R1
    tlr_loads_idcode_chk: assert property (@(posedge clk) disable iff (rst)
        tap_reset |=> ir_q == OP_IDCODE);

    // R2
    capture_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        (capture_ir && !tap_reset) |=> ir_sr == IR_CAPTURE_PAT);

endmodule

// File: rtl/jid_fuse.sv
module jid_fuse (
    input  logic clk,
    input  logic rst,
    input  logic fuse_prog_in,
    input  logic flash_rst,
    input  logic erase_stb,
    input  logic erase_done,
    output logic locked
);

    logic fuse_q;
    logic erase_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            fuse_q     <= fuse_prog_in;
            erase_pend <= 1'b0;
        end else if (erase_stb) begin
            erase_pend <= 1'b1;
        end else if (erase_pend && erase_done) begin
            fuse_q     <= 1'b0;
            erase_pend <= 1'b0;
        end
    end

    assign locked = fuse_q || flash_rst;

    // R7
    fuse_never_sets_chk: assert property (@(posedge clk) disable iff (rst)
        !fuse_q |=> !fuse_q);

    // R7
    clear_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (fuse_q && !erase_pend) |=> fuse_q);

    // R6
    flash_rst_locks_chk: assert property (@(posedge clk) disable iff (rst)
        flash_rst |-> locked);

endmodule

// File: rtl/jid_data_regs.sv
module jid_data_regs #(
    parameter int          ID_W     = 32,
    parameter logic [31:0] ID_VALUE = 32'h0ABC_D03F
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_bypass,
    input  logic sel_idcode,
    input  logic capture_dr,
    input  logic shift_dr,
    input  logic tdi,
    input  logic ext_dr_tdo,
    output logic dr_tdo
);

    localparam logic [ID_W-1:0] ID_CAPTURE = {ID_VALUE[ID_W-1:1], 1'b1};

    logic            byp_q;
    logic [ID_W-1:0] id_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            byp_q <= 1'b0;
        end else if (sel_bypass && capture_dr) begin
            byp_q <= 1'b0;
        end else if (sel_bypass && shift_dr) begin
            byp_q <= tdi;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            id_sr <= ID_CAPTURE;
        end else if (sel_idcode && capture_dr) begin
            id_sr <= ID_CAPTURE;
        end else if (sel_idcode && shift_dr) begin
            id_sr <= {tdi, id_sr[ID_W-1:1]};
        end
    end

    always_comb begin
        if (sel_idcode)      dr_tdo = id_sr[0];
        else if (sel_bypass) dr_tdo = byp_q;
        else                 dr_tdo = ext_dr_tdo;
    end

    // R10
    bypass_capture_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (capture_dr && sel_bypass) |=> !byp_q);

    // R11
    id_capture_lsb_chk: assert property (@(posedge clk) disable iff (rst)
        (capture_dr && sel_idcode) |=> id_sr[0]);

endmodule

// File: rtl/jtag_secure_ir_decode.sv
module jtag_secure_ir_decode
    import jid_pkg::*;
#(
    parameter int          ID_W     = 32,
    parameter logic [31:0] ID_VALUE = 32'h0ABC_D03F
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tap_reset,
    input  logic       capture_ir,
    input  logic       shift_ir,
    input  logic       update_ir,
    input  logic       capture_dr,
    input  logic       shift_dr,
    input  logic       update_dr,
    input  logic       tdi,
    input  logic       ext_dr_tdo,
    input  logic       fuse_prog_in,
    input  logic       flash_rst,
    input  logic       erase_done,
    output logic       ir_tdo,
    output logic       dr_tdo,
    output logic [4:0] active_ir,
    output logic       sel_bypass,
    output logic       sel_idcode,
    output logic       sel_bscan,
    output logic       sel_bus_ad,
    output logic       sel_bus_d,
    output logic       bsr_drive,
    output logic       bus_autoinc,
    output logic [1:0] bus_mode,
    output logic       sec_locked,
    output logic       sys_reset,
    output logic       reset_stb,
    output logic       erase_stb,
    output logic       halt_stb,
    output logic       cancel_stb,
    output logic       sync_stb
);

    opcode_t ir_sr;
    opcode_t ir_q;
    decode_t dec;
    strobe_t stb_q;
    logic    locked;

    jid_ir_reg u_ir (
        .clk        (clk),
        .rst        (rst),
        .tap_reset  (tap_reset),
        .capture_ir (capture_ir),
        .shift_ir   (shift_ir),
        .update_ir  (update_ir),
        .tdi        (tdi),
        .ir_sr      (ir_sr),
        .ir_q       (ir_q),
        .ir_tdo     (ir_tdo)
    );

    jid_fuse u_fuse (
        .clk          (clk),
        .rst          (rst),
        .fuse_prog_in (fuse_prog_in),
        .flash_rst    (flash_rst),
        .erase_stb    (stb_q.erase),
        .erase_done   (erase_done),
        .locked       (locked)
    );

    always_comb dec = decode_op(ir_q, locked);

    always_ff @(posedge clk) begin
        if (rst || tap_reset) begin
            stb_q <= '0;
        end else if (update_ir) begin
            stb_q <= strobe_of(ir_sr);
        end else if (update_dr) begin
            stb_q <= strobe_of(ir_q);
        end else begin
            stb_q <= '0;
        end
    end

    jid_data_regs #(
        .ID_W     (ID_W),
        .ID_VALUE (ID_VALUE)
    ) u_dregs (
        .clk        (clk),
        .rst        (rst),
        .sel_bypass (sel_bypass),
        .sel_idcode (sel_idcode),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .tdi        (tdi),
        .ext_dr_tdo (ext_dr_tdo),
        .dr_tdo     (dr_tdo)
    );

    assign active_ir   = ir_q;
    assign sel_bypass  = dec.sel[0];
    assign sel_idcode  = dec.sel[1];
    assign sel_bscan   = dec.sel[2];
    assign sel_bus_ad  = dec.sel[3];
    assign sel_bus_d   = dec.sel[4];
    assign bsr_drive   = dec.bsr_drive;
    assign bus_autoinc = dec.autoinc;
    assign bus_mode    = dec.mode;
    assign sec_locked  = locked;
    assign sys_reset   = (ir_q == OP_TGT_RST);
    assign reset_stb   = stb_q.reset;
    assign erase_stb   = stb_q.erase;
    assign halt_stb    = stb_q.halt;
    assign cancel_stb  = stb_q.cancel;
    assign sync_stb    = stb_q.sync;

    // R13
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({sel_bus_d, sel_bus_ad, sel_bscan, sel_idcode, sel_bypass}) == 1);

    // R5
    locked_no_block_chk: assert property (@(posedge clk) disable iff (rst)
        sec_locked |-> !sel_bus_d);

    // R8
    halt_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (update_ir && !tap_reset && ir_sr == OP_HALT) |=> halt_stb);

    // R9
    reset_is_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        sys_reset |-> (sel_bypass && !bsr_drive));

endmodule

// File: tb/tb_jtag_secure_ir_decode.sv
module tb_jtag_secure_ir_decode;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] ID_EXP     = 32'h0ABC_D03F;

    logic clk = 1'b0;
    logic rst, tap_reset, capture_ir, shift_ir, update_ir;
    logic capture_dr, shift_dr, update_dr, tdi, ext_dr_tdo;
    logic fuse_prog_in, flash_rst, erase_done;
    logic ir_tdo, dr_tdo;
    logic [4:0] active_ir;
    logic sel_bypass, sel_idcode, sel_bscan, sel_bus_ad, sel_bus_d;
    logic bsr_drive, bus_autoinc, sec_locked, sys_reset;
    logic [1:0] bus_mode;
    logic reset_stb, erase_stb, halt_stb, cancel_stb, sync_stb;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jtag_secure_ir_decode #(.ID_VALUE(ID_EXP)) dut (
        .clk(clk), .rst(rst), .tap_reset(tap_reset),
        .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .ext_dr_tdo(ext_dr_tdo), .fuse_prog_in(fuse_prog_in),
        .flash_rst(flash_rst), .erase_done(erase_done),
        .ir_tdo(ir_tdo), .dr_tdo(dr_tdo), .active_ir(active_ir),
        .sel_bypass(sel_bypass), .sel_idcode(sel_idcode), .sel_bscan(sel_bscan),
        .sel_bus_ad(sel_bus_ad), .sel_bus_d(sel_bus_d), .bsr_drive(bsr_drive),
        .bus_autoinc(bus_autoinc), .bus_mode(bus_mode), .sec_locked(sec_locked),
        .sys_reset(sys_reset), .reset_stb(reset_stb), .erase_stb(erase_stb),
        .halt_stb(halt_stb), .cancel_stb(cancel_stb), .sync_stb(sync_stb)
    );

    // select vector order: {bus_d, bus_ad, bscan, idcode, bypass}
    function automatic logic [4:0] sel_vec();
        return {sel_bus_d, sel_bus_ad, sel_bscan, sel_idcode, sel_bypass};
    endfunction

    function automatic logic [4:0] stb_vec();
        return {sync_stb, cancel_stb, halt_stb, erase_stb, reset_stb};
    endfunction

    function automatic logic [4:0] exp_sel(logic [4:0] op, logic lk);
        if (lk && (op == 5'h10 || op == 5'h11 || op == 5'h12 || op == 5'h15))
            return 5'b00001;
        case (op)
            5'h01:                      return 5'b00010;
            5'h02, 5'h03, 5'h04:        return 5'b00100;
            5'h10, 5'h11, 5'h14, 5'h15: return 5'b01000;
            5'h12:                      return 5'b10000;
            default:                    return 5'b00001;
        endcase
    endfunction

    function automatic logic [4:0] exp_stb(logic [4:0] op);
        case (op)
            5'h0C:   return 5'b00001;
            5'h0F:   return 5'b00010;
            5'h1C:   return 5'b00100;
            5'h13:   return 5'b01000;
            5'h17:   return 5'b10000;
            default: return 5'b00000;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic fuse);
        @(negedge clk);
        rst = 1'b1; fuse_prog_in = fuse;
        tap_reset = 0; capture_ir = 0; shift_ir = 0; update_ir = 0;
        capture_dr = 0; shift_dr = 0; update_dr = 0; tdi = 0;
        flash_rst = 0; erase_done = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic load_ir(logic [4:0] op, output logic [4:0] shifted);
        capture_ir = 1'b1;
        @(negedge clk);
        capture_ir = 1'b0; shift_ir = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tdi = op[i];
            shifted[i] = ir_tdo;
            @(negedge clk);
        end
        shift_ir = 1'b0; update_ir = 1'b1;
        @(negedge clk);
        update_ir = 1'b0;
    endtask

    task automatic pulse_update_dr();
        update_dr = 1'b1;
        @(negedge clk);
        update_dr = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset(1'b0);
        check("R1 reset active_ir", active_ir, 5'h01);
        check("R1 reset select", sel_vec(), 5'b00010);
        check("R13 reset strobes idle", stb_vec(), 5'b0);
        check("R6 fuse clear unlocked", sec_locked, 1'b0);
    endtask

    task automatic t_capture_ir();
        logic [4:0] so;
        load_ir(5'h1F, so);
        check("R2 capture pattern out", so, 5'b00001);
        load_ir(5'h03, so);
        check("R2 capture pattern again", so, 5'b00001);
    endtask

    task automatic t_sweep(logic lk);
        logic [4:0] so;
        for (int k = 0; k < 32; k++) begin
            logic [4:0] op;
            op = 5'(k);
            load_ir(op, so);
            check(lk ? "R5 locked select" : "R3 R4 select", sel_vec(), exp_sel(op, lk));
            check("R8 R4 strobe after update_ir", stb_vec(), exp_stb(op));
            check("R12 bsr_drive", bsr_drive,
                  (op == 5'h03 || op == 5'h04 || op == 5'h06));
            check("R12 autoinc", bus_autoinc, (!lk && op == 5'h12));
            check("R9 sys_reset level", sys_reset, (op == 5'h0C));
            if (exp_sel(op, lk) == 5'b01000) begin
                check("R12 bus_mode", bus_mode,
                      (op == 5'h15) ? 2'd1 : (op == 5'h10) ? 2'd2 :
                      (op == 5'h14) ? 2'd3 : 2'd0);
            end
            @(negedge clk);
            check("R8 strobe one cycle", stb_vec(), 5'b0);
        end
    endtask

    task automatic t_update_dr_strobes();
        logic [4:0] so;
        load_ir(5'h1C, so);
        @(negedge clk);
        pulse_update_dr();
        check("R8 halt on update_dr", stb_vec(), 5'b00100);
        load_ir(5'h17, so);
        @(negedge clk);
        pulse_update_dr();
        check("R8 sync on update_dr", stb_vec(), 5'b10000);
        load_ir(5'h0C, so);
        repeat (4) @(negedge clk);
        check("R9 sys_reset held", sys_reset, 1'b1);
        load_ir(5'h1F, so);
        check("R9 sys_reset released", sys_reset, 1'b0);
    endtask

    task automatic t_tlr();
        logic [4:0] so;
        load_ir(5'h12, so);
        tap_reset = 1'b1;
        @(negedge clk);
        tap_reset = 1'b0;
        check("R1 tlr active_ir", active_ir, 5'h01);
        check("R1 tlr select", sel_vec(), 5'b00010);
    endtask

    task automatic t_bypass_dr();
        logic [4:0] so;
        logic [3:0] outb;
        logic [3:0] pat;
        pat = 4'b1101;
        load_ir(5'h1F, so);
        capture_dr = 1'b1;
        @(negedge clk);
        capture_dr = 1'b0; shift_dr = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tdi = pat[i];
            outb[i] = dr_tdo;
            @(negedge clk);
        end
        shift_dr = 1'b0;
        check("R10 bypass delays tdi", outb, {pat[2:0], 1'b0});
        check("R10 bypass last bit", dr_tdo, pat[3]);
    endtask

    task automatic t_idcode_dr();
        logic [4:0]  so;
        logic [31:0] outw;
        load_ir(5'h01, so);
        capture_dr = 1'b1;
        @(negedge clk);
        capture_dr = 1'b0; shift_dr = 1'b1;
        for (int i = 0; i < 32; i++) begin
            tdi = 1'b0;
            outw[i] = dr_tdo;
            @(negedge clk);
        end
        shift_dr = 1'b0;
        check("R11 idcode shifted out", outw, {ID_EXP[31:1], 1'b1});
    endtask

    task automatic t_ext_chain();
        logic [4:0] so;
        load_ir(5'h02, so);
        ext_dr_tdo = 1'b1;
        #1;
        check("R3 boundary chain forwarded", dr_tdo, 1'b1);
        ext_dr_tdo = 1'b0;
        #1;
        check("R3 boundary chain forwarded low", dr_tdo, 1'b0);
    endtask

    task automatic t_lock_erase();
        logic [4:0] so;
        do_reset(1'b1);
        check("R6 fuse loaded locked", sec_locked, 1'b1);
        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0;
        @(negedge clk);
        check("R7 stray erase_done ignored", sec_locked, 1'b1);
        load_ir(5'h11, so);
        check("R5 word blocked", sel_vec(), 5'b00001);
        load_ir(5'h14, so);
        check("R5 service allowed", sel_vec(), 5'b01000);
        load_ir(5'h0F, so);
        check("R7 erase strobe", erase_stb, 1'b1);
        check("R7 still locked before done", sec_locked, 1'b1);
        repeat (3) @(negedge clk);
        check("R7 locked while pending", sec_locked, 1'b1);
        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0;
        check("R7 unlocked after done", sec_locked, 1'b0);
        load_ir(5'h12, so);
        check("R7 block access restored", sel_vec(), 5'b10000);
        flash_rst = 1'b1;
        @(negedge clk);
        check("R6 flash_rst locks", sec_locked, 1'b1);
        check("R6 flash_rst blocks select", sel_vec(), 5'b00001);
        check("R6 flash_rst clears autoinc", bus_autoinc, 1'b0);
        flash_rst = 1'b0;
        @(negedge clk);
        check("R6 lock lifts with flash_rst", sel_vec(), 5'b10000);
    endtask

    initial begin
        ext_dr_tdo = 1'b0;
        rst = 1'b1;
        t_reset_state();
        t_capture_ir();
        t_sweep(1'b0);
        t_update_dr_strobes();
        t_tlr();
        t_bypass_dr();
        t_idcode_dr();
        t_ext_chain();
        t_lock_erase();
        flash_rst = 1'b1;
        @(negedge clk);
        t_sweep(1'b1);
        flash_rst = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule